// File: doc/BRIEF.md
# PCI Target Write Data-Phase Bridge

This block sits on the target side of a 32-bit PCI bus and turns memory-write bursts into single-cycle strobes on a simple local back end. It watches the address phase for a memory-write command whose address falls inside one of six base-address windows. It claims the transaction by driving `devseln` low. Each completed data phase is then handed to the back end as a data word, the byte enables, the word address and an active-low transfer strobe.

The back end paces the bus through an active-low ready input. The bus ready output `trdyn` is only asserted while the back end is ready, so the local side can insert target wait states. Master wait states reach the back end as gaps in the strobe, one cycle late, because the strobe is registered from the previous cycle's `irdyn` and local ready. When the master marks the last data phase, the bridge drives `devseln` and `trdyn` high for one cycle and then releases them.

Top module: `pciw_wr_bridge`

## Requirements
- R1: During and right after reset, `devseln_o` and `trdyn_o` are released (high-impedance), `loc_xfern_o` is high, `loc_wr_o` is low and `loc_bar_hit_o` is zero.
- R2: A falling `framen_i` with `cben_i` = 4'b0111 (memory write) and an address inside BAR window i sets bit i of `loc_bar_hit_o` and drives `devseln_o` low from the second cycle after the address phase until the final data phase completes.
- R3: An address outside all windows, or any command other than 4'b0111, is not claimed: `devseln_o` and `trdyn_o` stay released and `loc_xfern_o` stays high.
- R4: While the transaction is claimed and data phases are in progress, `trdyn_o` is low exactly in the cycles where `loc_rdyn_i` is low.
- R5: A data phase completes on a clock edge where `irdyn_i` and `trdyn_o` are both low. In the following cycle `loc_xfern_o` is low and `loc_wdata_o` holds the `ad_i` word from that edge.
- R6: In any cycle that follows a cycle with `irdyn_i` high, `loc_xfern_o` is high.
- R7: `loc_waddr_o` is the address from the address phase for the first completed phase, and it grows by 4 for each later completed phase of the same burst.
- R8: After the data phase completed with `framen_i` high, `devseln_o` and `trdyn_o` are driven high for one cycle and released in the cycle after that. A new transaction can then start.
- R9: `loc_be_o` holds the `cben_i` value of the completed phase, which may differ from phase to phase.
- R10: `loc_wr_o` is high from the first data-phase cycle of a claimed write up to and including the turnaround cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| framen_i | input | 1 | Bus frame, active low |
| irdyn_i | input | 1 | Initiator ready, active low |
| cben_i | input | 4 | Command in address phase, active-low byte enables in data phases |
| ad_i | input | 32 | Address/data bus |
| devseln_o | output | 1 | Device select, active low, high-impedance when not driven |
| trdyn_o | output | 1 | Target ready, active low, high-impedance when not driven |
| loc_rdyn_i | input | 1 | Back-end ready, active low |
| loc_wdata_o | output | 32 | Write data of the last completed phase |
| loc_be_o | output | 4 | Byte enables of the last completed phase |
| loc_waddr_o | output | 32 | Word address of the last completed phase |
| loc_wr_o | output | 1 | Write transaction in progress |
| loc_bar_hit_o | output | 6 | One bit per matched base-address window |
| loc_xfern_o | output | 1 | Transfer strobe, active low |

## Verification
Two things often happen in the same cycle: a master wait state, with `irdyn` high, and a target wait state, with local ready high. A third case is the final data phase, with `framen` high, held back by a target wait. The bench builds bursts in which the master and the back end each stall at random, and it holds the last phase open across back-end stalls. Each cycle it compares the strobe, the ready lines and the captured word against a behavioural model. That shows that only a cycle in which both sides were ready yields a strobe, and that the turnaround starts only after the final phase really completes.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_DATA   = 2'd2,
    ST_TURN   = 2'd3
  } pciw_state_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pciw_bar_decode.sv
module pciw_bar_decode #(
  parameter int NUM_BAR  = 6,
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 12,
  parameter logic [NUM_BAR*ADDR_W-1:0] BAR_BASE = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_BAR-1:0] hit_o
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1));

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    logic [ADDR_W-1:0] base;
    assign base     = BAR_BASE[g*ADDR_W +: ADDR_W];
    assign hit_o[g] = ((addr_i ^ base) & WIN_MASK) == '0;
  end
endmodule

// File: rtl/pciw_fsm.sv
module pciw_fsm
  import pciw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        framen_i,
  input  logic        irdyn_i,
  input  logic [3:0]  cben_i,
  input  logic        loc_rdyn_i,
  input  logic        hit_any_i,
  output pciw_state_e state_o,
  output logic        addr_cap_o,
  output logic        done_o
);
  pciw_state_e state_q, state_d;
  logic        framen_q;

  // address phase is the first cycle of a falling frame
  assign addr_cap_o = (state_q == ST_IDLE) && framen_q && !framen_i
                      && (cben_i == CMD_MEM_WR);
  assign done_o     = (state_q == ST_DATA) && !irdyn_i && !loc_rdyn_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (addr_cap_o) state_d = ST_DECODE;
      ST_DECODE: state_d = hit_any_i ? ST_DATA : ST_IDLE;
      ST_DATA:   if (done_o && framen_i) state_d = ST_TURN;
      ST_TURN:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      framen_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      framen_q <= framen_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pciw_datapath.sv
module pciw_datapath #(
  parameter int NUM_BAR = 6,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BE_W    = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_cap_i,
  input  logic               done_i,
  input  logic [DATA_W-1:0]  ad_i,
  input  logic [BE_W-1:0]    cben_i,
  input  logic [NUM_BAR-1:0] hit_vec_i,
  output logic [NUM_BAR-1:0] hit_q_o,
  output logic [ADDR_W-1:0]  waddr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [BE_W-1:0]    be_o,
  output logic               xfern_o
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BE_W);

  logic [ADDR_W-1:0]  addr_q;
  logic [NUM_BAR-1:0] hit_q;
  logic [ADDR_W-1:0]  waddr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;
  logic               xfern_q;

  // address and window hit, enabled in the address phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
    end else if (addr_cap_i) begin
      hit_q <= hit_vec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_cap_i) begin
      addr_q <= ad_i[ADDR_W-1:0];
    end else if (done_i) begin
      addr_q <= addr_q + ADDR_STEP;
    end
  end

  // back-end word, enabled on each completed phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (done_i) begin
      waddr_q <= addr_q;
      wdata_q <= ad_i;
      be_q    <= cben_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfern_q <= 1'b1;
    end else begin
      xfern_q <= !done_i;
    end
  end

  assign hit_q_o = hit_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;
  assign be_o    = be_q;
  assign xfern_o = xfern_q;
endmodule

// File: rtl/pciw_wr_bridge.sv
module pciw_wr_bridge
  import pciw_pkg::*;
#(
  parameter int NUM_BAR  = 6,
  parameter int WIN_LOG2 = 12,
  parameter logic [NUM_BAR*32-1:0] BAR_BASE = {
    32'h6000_0000, 32'h5000_0000, 32'h4000_0000,
    32'h3000_0000, 32'h2000_0000, 32'h1000_0000
  }
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               framen_i,
  input  logic               irdyn_i,
  input  logic [3:0]         cben_i,
  input  logic [31:0]        ad_i,
  output logic               devseln_o,
  output logic               trdyn_o,
  input  logic               loc_rdyn_i,
  output logic [31:0]        loc_wdata_o,
  output logic [3:0]         loc_be_o,
  output logic [31:0]        loc_waddr_o,
  output logic               loc_wr_o,
  output logic [NUM_BAR-1:0] loc_bar_hit_o,
  output logic               loc_xfern_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_q_n;
  pciw_state_e        state;
  logic               addr_cap;
  logic               done;
  logic [NUM_BAR-1:0] hit_vec;
  logic [NUM_BAR-1:0] hit_q;
  logic               active;
  logic               devsel_oe, devsel_val, trdy_oe, trdy_val;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  pciw_bar_decode #(
    .NUM_BAR(NUM_BAR), .ADDR_W(32), .WIN_LOG2(WIN_LOG2), .BAR_BASE(BAR_BASE)
  ) u_dec (
    .addr_i(ad_i),
    .hit_o (hit_vec)
  );

  pciw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .framen_i  (framen_i),
    .irdyn_i   (irdyn_i),
    .cben_i    (cben_i),
    .loc_rdyn_i(loc_rdyn_i),
    .hit_any_i (|hit_q),
    .state_o   (state),
    .addr_cap_o(addr_cap),
    .done_o    (done)
  );

  pciw_datapath #(.NUM_BAR(NUM_BAR), .ADDR_W(32), .DATA_W(32)) u_dp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .addr_cap_i(addr_cap),
    .done_i    (done),
    .ad_i      (ad_i),
    .cben_i    (cben_i),
    .hit_vec_i (hit_vec),
    .hit_q_o   (hit_q),
    .waddr_o   (loc_waddr_o),
    .wdata_o   (loc_wdata_o),
    .be_o      (loc_be_o),
    .xfern_o   (loc_xfern_o)
  );

  assign active     = (state == ST_DATA) || (state == ST_TURN);
  assign devsel_oe  = active;
  assign devsel_val = (state == ST_TURN);
  assign trdy_oe    = active;
  assign trdy_val   = (state == ST_TURN) || loc_rdyn_i;

  assign devseln_o     = devsel_oe ? devsel_val : 1'bz;
  assign trdyn_o       = trdy_oe   ? trdy_val   : 1'bz;
  assign loc_wr_o      = active;
  assign loc_bar_hit_o = active ? hit_q : '0;
endmodule

// File: rtl/pciw_chk.sv
module pciw_chk
  import pciw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        irdyn,
  input logic        loc_rdyn,
  input pciw_state_e state,
  input logic        devsel_oe,
  input logic        devsel_val,
  input logic        trdy_oe,
  input logic        trdy_val,
  input logic        xfern,
  input logic [31:0] waddr
);
  // R2
  devsel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (devsel_oe && !devsel_val));

  // R4
  trdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_val) |-> !loc_rdyn);

  // R5
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfern |-> $past(!irdyn && !loc_rdyn));

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irdyn |=> xfern);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfern && $past(!xfern)) |-> (waddr == $past(waddr) + 32'd4));

  // R8
  turn_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> (devsel_oe && devsel_val && trdy_oe && trdy_val));

  // R8
  turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |=> (!devsel_oe && !trdy_oe));
endmodule

bind pciw_wr_bridge pciw_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .irdyn     (irdyn_i),
  .loc_rdyn  (loc_rdyn_i),
  .state     (state),
  .devsel_oe (devsel_oe),
  .devsel_val(devsel_val),
  .trdy_oe   (trdy_oe),
  .trdy_val  (trdy_val),
  .xfern     (loc_xfern_o),
  .waddr     (loc_waddr_o)
);

// File: tb/pciw_wr_bridge_test.sv
`timescale 1ns/1ps
module pciw_wr_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        framen, irdyn, lrdyn;
  logic [3:0]  cben;
  logic [31:0] ad;
  wire         devsel_w, trdy_w;
  logic [31:0] wdata, waddr;
  logic [3:0]  be;
  logic        wr, xfern;
  logic [5:0]  hit;

  pullup (devsel_w);
  pullup (trdy_w);

  always #10 clk = ~clk;

  pciw_wr_bridge uut (
    .clk(clk), .rst_n(rst_n), .framen_i(framen), .irdyn_i(irdyn),
    .cben_i(cben), .ad_i(ad), .devseln_o(devsel_w), .trdyn_o(trdy_w),
    .loc_rdyn_i(lrdyn), .loc_wdata_o(wdata), .loc_be_o(be),
    .loc_waddr_o(waddr), .loc_wr_o(wr), .loc_bar_hit_o(hit), .loc_xfern_o(xfern)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  // behavioural reference: 0 idle, 1 decode, 2 data, 3 turnaround
  int          m_st;
  logic        m_fq, m_xfer, m_pirdy;
  logic [31:0] m_addr, m_data, m_wa;
  logic [3:0]  m_be;
  logic [5:0]  m_hit;

  function automatic logic [5:0] win_hit(logic [31:0] a);
    logic [5:0] h = '0;
    for (int i = 0; i < 6; i++)
      if (a[31:12] == 20'((i + 1) << 16)) h[i] = 1'b1;
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_fq <= 1'b1; m_xfer <= 1'b1; m_pirdy <= 1'b1;
      m_addr <= '0; m_data <= '0; m_wa <= '0; m_be <= '0; m_hit <= '0;
    end else begin
      automatic logic fin = (m_st == 2) && !irdyn && !lrdyn;
      cyc_cnt <= cyc_cnt + 1;
      m_fq    <= framen;
      m_pirdy <= irdyn;
      m_xfer  <= !fin;
      if (fin) begin
        m_data <= ad; m_be <= cben; m_wa <= m_addr; m_addr <= m_addr + 4;
      end
      if (m_st == 0 && m_fq && !framen && cben == 4'b0111) begin
        m_addr <= ad; m_hit <= win_hit(ad); m_st <= 1;
      end else if (m_st == 1) m_st <= (m_hit != 0) ? 2 : 0;
      else if (m_st == 2 && fin && framen) m_st <= 3;
      else if (m_st == 3) m_st <= 0;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic act_on = (m_st >= 2);
    chk(m_st == 3 ? "R8" : "R2", "devseln", 32'(devsel_w), 32'(m_st == 2 ? 1'b0 : 1'b1));
    chk(m_st == 3 ? "R8" : "R4", "trdyn", 32'(trdy_w), 32'(m_st == 2 ? lrdyn : 1'b1));
    chk(m_pirdy ? "R6" : "R5", "xfern", 32'(xfern), 32'(m_xfer));
    chk("R2", "bar_hit", 32'(hit), 32'(act_on ? m_hit : 6'd0));
    chk("R10", "wr", 32'(wr), 32'(act_on));
    if (!m_xfer) begin
      chk("R5", "wdata", wdata, m_data);
      chk("R9", "be", 32'(be), 32'(m_be));
      chk("R7", "waddr", waddr, m_wa);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      framen = 1'b1; irdyn = 1'b1; cben = 4'h0; ad = '0;
      lrdyn = ($urandom % 2) == 0;
    end
  endtask

  // claimed write burst; mw/tw = master/target wait chance in quarters
  task automatic burst(logic [31:0] a, int n, int mw, int tw);
    int k = 0;
    logic held = 1'b0;
    cyc();
    framen = 1'b0; irdyn = 1'b1; cben = 4'b0111; ad = a;
    while (k < n) begin
      cyc();
      if (!m_xfer && held) begin k++; held = 1'b0; end
      if (k < n) begin
        if (!held) begin
          ad   = {a[15:0], 16'(k)} ^ $urandom;
          cben = 4'($urandom);
          held = int'($urandom % 4) >= mw;
        end
        irdyn  = !held;
        framen = held && (k == n - 1);
        lrdyn  = int'($urandom % 4) < tw;
      end else begin
        framen = 1'b1; irdyn = 1'b1; cben = 4'h0; ad = '0;
      end
    end
    idle(2);
  endtask

  task automatic no_claim(logic [31:0] a, logic [3:0] cmd);
    cyc();
    framen = 1'b0; irdyn = 1'b1; cben = cmd; ad = a; lrdyn = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk("R3", "devseln released", 32'(devsel_w), 32'd1);
      chk("R3", "xfern idle", 32'(xfern), 32'd1);
      irdyn = 1'b0; cben = 4'h0; ad = $urandom; framen = (i == 5);
    end
    cyc();
    framen = 1'b1; irdyn = 1'b1;
    idle(2);
  endtask

  initial begin
    framen = 1'b1; irdyn = 1'b1; cben = 4'h0; ad = '0; lrdyn = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset devseln", 32'(devsel_w), 32'd1);
    chk("R1", "reset trdyn", 32'(trdy_w), 32'd1);
    chk("R1", "reset xfern", 32'(xfern), 32'd1);
    chk("R1", "reset wr", 32'(wr), 32'd0);
    chk("R1", "reset hit", 32'(hit), 32'd0);
    rst_n = 1'b1;
    idle(4);

    burst(32'h1000_0000, 4, 0, 0);   // no waits, BAR0
    burst(32'h2000_0100, 5, 2, 0);   // master waits, BAR1
    burst(32'h3000_0040, 5, 0, 2);   // target waits, BAR2
    burst(32'h4000_0800, 8, 2, 2);   // both sides stall, BAR3
    burst(32'h5000_0010, 1, 0, 0);   // single phase, BAR4
    burst(32'h6000_0FFC, 1, 1, 3);   // top word of BAR5 window
    no_claim(32'h6000_1000, 4'b0111); // just past BAR5 window
    no_claim(32'h1000_0000, 4'b0110); // read command
    burst(32'h1000_0200, 3, 3, 3);   // heavy stalls on last phase
    burst(32'h2000_0000, 2, 0, 0);   // back-to-back
    burst(32'h3000_0000, 2, 0, 0);
    for (int t = 0; t < 20; t++)
      burst(32'((t % 6 + 1) << 28) | 32'(($urandom % 256) * 4), 1 + int'($urandom % 6),
            int'($urandom % 3), int'($urandom % 3));
    idle(3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc_cnt > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp<100000", cyc_cnt);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule